// File: doc/BRIEF.md
# Interrupt Acknowledge and Priority Stack

This block is the acknowledge and end-of-interrupt front end of a vectored interrupt controller. An arbiter outside the block supplies the highest pending request as a valid flag, a priority and a vector. The block compares that priority with its current-priority register and raises a request line to the processor only when the pending priority is strictly higher. It keeps earlier priorities on a small hardware stack (last in, first out) so that interrupt service can nest.

Software sees two registers on a simple single-cycle 32-bit bus. The acknowledge register, at offset 0x10, returns the vector table base combined with the vector that was latched when the request line last rose. In software-vector mode a read of it accepts the request: the current priority is pushed, the pending priority becomes current, and the request line drops in that same cycle. A write of any data to the end-of-interrupt register, at offset 0x18, pops the saved priority back into the current-priority register. A mode input selects the vector table entry size, which moves the vector field by one bit.

The request tracker is a two-state machine. REQ_QUIET means the line is low and REQ_RAISED means it is high. The RISE transition (REQ_QUIET to REQ_RAISED) fires when a qualifying request is present and is not being taken in the same cycle, and it latches the vector. The HOLD transition keeps REQ_RAISED while the request stays qualified. The DROP transition (REQ_RAISED to REQ_QUIET) fires when the request no longer qualifies or is taken by an acknowledge read.

Top module: `irq_ack_stack`

## Requirements
- R1: After reset, the current priority, both sticky flags and the request line are 0, and an acknowledge read with nothing pending returns 0.
- R2: The request line is high exactly when the pending request is valid, its priority is strictly greater than the current priority, and no acknowledge read is taking it in that cycle.
- R3: An acknowledge read in software-vector mode (`sw_mode`=1) while the request qualifies does three things. It pushes the current priority, it makes the pending priority current from the next cycle, and it holds the request line low during the read cycle.
- R4: An acknowledge read with `sw_mode`=0, or with no qualifying request, changes neither the current priority nor the stack.
- R5: A write of any data to offset 0x18 moves the most recently pushed priority into the current-priority register from the next cycle.
- R6: A read of offset 0x18 returns 0 and changes neither the current priority nor the stack.
- R7: With `entry_wide`=0, an acknowledge read returns the table base in bits 31:11, the vector in bits 10:2, and 0 in bits 1:0 (bit 0 is the least significant bit).
- R8: With `entry_wide`=1, an acknowledge read returns the upper 20 base bits in bits 31:12, the vector in bits 11:3, and 0 in bits 2:0.
- R9: The vector is latched from `pend_vec` in the cycle the request line rises, in either vector mode. It is held unchanged while the line stays high and afterwards. When the rise happens in the same cycle as an acknowledge read, that read returns the vector being latched.
- R10: A push onto a full stack (DEPTH entries) is dropped and sets the sticky `lifo_ovf`. The pending priority still becomes current.
- R11: A pop from an empty stack leaves the current priority unchanged and sets the sticky `lifo_udf`.
- R12: A write to offset 0x10 loads the table base from write-data bits 31:11 and does not change the priority. Accesses to any other offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pend_valid | input | 1 | A pending request is present |
| pend_prio | input | PRIO_W | Priority of the pending request |
| pend_vec | input | VEC_W | Vector of the pending request |
| sw_mode | input | 1 | 1 = software-vector mode |
| entry_wide | input | 1 | Vector table entry-size select |
| irq_out | output | 1 | Interrupt request to the processor |
| cur_prio | output | PRIO_W | Current-priority register |
| lifo_ovf | output | 1 | Sticky stack overflow flag |
| lifo_udf | output | 1 | Sticky stack underflow flag |

## Verification
The bench builds the block with DEPTH=4 and PRIO_W=4, VEC_W=9 and ADDR_W=8 at their defaults. With only four entries, a directed run of five nested acknowledges fills the stack and then overflows it. The stack then drains to underflow within a few cycles. The random phase also reaches the full and empty boundaries many times, and it mixes both vector modes and both entry sizes. Because there are only sixteen priority levels, the equal-priority case, where the line must stay low, comes up often without any steering.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic {
        REQ_QUIET  = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_e;

    typedef enum logic [2:0] {
        ACC_NONE   = 3'd0,
        ACC_ACK_RD = 3'd1,
        ACC_ACK_WR = 3'd2,
        ACC_EOI_RD = 3'd3,
        ACC_EOI_WR = 3'd4
    } acc_kind_e;

endpackage

// File: rtl/prio_lifo.sv
module prio_lifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic              empty,
    output logic              full
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]               cnt_q;
    logic [DEPTH-1:0][DATA_W-1:0]   slots;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (push && !full && (cnt_q == CNT_W'(i))) begin
                cell_q <= push_data;
            end
        end
        assign slots[i] = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pop_data = slots[AW'(cnt_q - 1'b1)];

    // R10: the controller never pushes onto a full stack
    p_push_not_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R11: the controller never pops an empty stack
    p_pop_not_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R3: each push adds one entry
    p_push_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    // R5: each pop removes one entry
    p_pop_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_ack_pkg::*;
#(
    parameter int VEC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_req,
    input  logic             ack_take,
    input  logic [VEC_W-1:0] pend_vec,
    output logic             irq_out,
    output logic [VEC_W-1:0] vec_view
);
    req_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_QUIET:  if (raw_req && !ack_take) state_d = REQ_RAISED;  // RISE
            REQ_RAISED: if (!raw_req || ack_take) state_d = REQ_QUIET;   // DROP
            default:    state_d = REQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_QUIET;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == REQ_QUIET && raw_req) begin
                vec_q <= pend_vec;
            end
        end
    end

    always_comb begin
        irq_out  = raw_req && !ack_take;
        vec_view = vec_q;
        unique case (state_q)
            REQ_QUIET:  if (raw_req) vec_view = pend_vec;
            REQ_RAISED: vec_view = vec_q;
            default:    vec_view = vec_q;
        endcase
    end

    // R9: the latched vector does not move while the line is up
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == REQ_RAISED) |=> $stable(vec_q));
    // R9: a rise latches the pending vector
    p_rise_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == REQ_QUIET && raw_req) |=> vec_q == $past(pend_vec));
    // R3: a taken request leaves the machine quiet
    p_take_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> state_q == REQ_QUIET);

endmodule

// File: rtl/ack_word_pack.sv
module ack_word_pack
    import irq_ack_pkg::*;
#(
    parameter int VEC_W = 9
) (
    input  logic [WORD_W-3-VEC_W:0] base,
    input  logic [VEC_W-1:0]        vec,
    input  logic                    wide,
    output logic [WORD_W-1:0]       word
);
    localparam int BASE_W = WORD_W - 2 - VEC_W;

    always_comb begin
        if (wide) begin
            word = {base[BASE_W-1:1], vec, 3'b000};
        end else begin
            word = {base, vec, 2'b00};
        end
    end

endmodule

// File: rtl/irq_ack_stack.sv
module irq_ack_stack
    import irq_ack_pkg::*;
#(
    parameter int                PRIO_W  = 4,
    parameter int                VEC_W   = 9,
    parameter int                DEPTH   = 16,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] ACK_OFS = 'h10,
    parameter logic [ADDR_W-1:0] EOI_OFS = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pend_valid,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic [VEC_W-1:0]  pend_vec,
    input  logic              sw_mode,
    input  logic              entry_wide,
    output logic              irq_out,
    output logic [PRIO_W-1:0] cur_prio,
    output logic              lifo_ovf,
    output logic              lifo_udf
);
    localparam int BASE_W = WORD_W - 2 - VEC_W;

    acc_kind_e          acc;
    logic [PRIO_W-1:0]  cur_q, cur_d, pop_data;
    logic [BASE_W-1:0]  base_q;
    logic [VEC_W-1:0]   vec_view;
    logic [WORD_W-1:0]  ack_word;
    logic               raw_req, ack_take, lifo_empty, lifo_full;
    logic               do_push, do_pop, ovf_q, udf_q;
    logic               unused_wbits;

    assign unused_wbits = ^bus_wdata[31-BASE_W:0];

    always_comb begin
        acc = ACC_NONE;
        if (bus_sel && bus_addr == ACK_OFS) begin
            acc = bus_we ? ACC_ACK_WR : ACC_ACK_RD;
        end else if (bus_sel && bus_addr == EOI_OFS) begin
            acc = bus_we ? ACC_EOI_WR : ACC_EOI_RD;
        end
    end

    assign raw_req  = pend_valid && (pend_prio > cur_q);
    assign ack_take = (acc == ACC_ACK_RD) && sw_mode && raw_req;
    assign do_push  = ack_take && !lifo_full;
    assign do_pop   = (acc == ACC_EOI_WR) && !lifo_empty;

    always_comb begin
        cur_d = cur_q;
        unique case (acc)
            ACC_ACK_RD: if (ack_take) cur_d = pend_prio;
            ACC_EOI_WR: if (!lifo_empty) cur_d = pop_data;
            default:    cur_d = cur_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            base_q <= '0;
            ovf_q  <= 1'b0;
            udf_q  <= 1'b0;
        end else begin
            cur_q <= cur_d;
            if (acc == ACC_ACK_WR) base_q <= bus_wdata[31 -: BASE_W];
            if (ack_take && lifo_full) ovf_q <= 1'b1;
            if (acc == ACC_EOI_WR && lifo_empty) udf_q <= 1'b1;
        end
    end

    prio_lifo #(
        .DEPTH  (DEPTH),
        .DATA_W (PRIO_W)
    ) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (cur_q),
        .pop_data  (pop_data),
        .empty     (lifo_empty),
        .full      (lifo_full)
    );

    irq_req_fsm #(
        .VEC_W (VEC_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_req  (raw_req),
        .ack_take (ack_take),
        .pend_vec (pend_vec),
        .irq_out  (irq_out),
        .vec_view (vec_view)
    );

    ack_word_pack #(
        .VEC_W (VEC_W)
    ) u_pack (
        .base (base_q),
        .vec  (vec_view),
        .wide (entry_wide),
        .word (ack_word)
    );

    assign bus_rdata = (acc == ACC_ACK_RD) ? ack_word : '0;
    assign cur_prio  = cur_q;
    assign lifo_ovf  = ovf_q;
    assign lifo_udf  = udf_q;

    // R2: an equal priority never raises the line
    p_equal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && pend_prio == cur_prio) |-> !irq_out);
    // R3: a taken request becomes current and the line is low meanwhile
    p_take_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> cur_prio == $past(pend_prio));
    p_take_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |-> !irq_out);
    // R4: a hardware-mode acknowledge read keeps the priority
    p_hw_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_ACK_RD && !sw_mode) |=> $stable(cur_prio));
    // R5: an end-of-interrupt write restores the stacked priority
    p_pop_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_EOI_WR && !lifo_empty) |=> cur_prio == $past(pop_data));
    // R6: an end-of-interrupt read is inert and returns zero
    p_eoi_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_EOI_RD) |=> $stable(cur_prio));
    p_eoi_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_EOI_RD) |-> bus_rdata == '0);
    // R7: reserved low bits of the acknowledge word
    p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_ACK_RD) |-> bus_rdata[1:0] == 2'b00);
    // R8: wide entries clear one more low bit
    p_wide_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_ACK_RD && entry_wide) |-> bus_rdata[2] == 1'b0);
    // R10: overflow is sticky
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lifo_ovf |=> lifo_ovf);
    // R11: an empty pop keeps the priority and flags underflow
    p_udf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_EOI_WR && lifo_empty) |=> ($stable(cur_prio) && lifo_udf));
    // R12: a base write leaves the priority alone
    p_base_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_ACK_WR) |=> $stable(cur_prio));

endmodule

// File: tb/irq_ack_stack_bench.sv
module irq_ack_stack_bench;
    localparam int DEPTH = 4;
    localparam int OP_IDLE = 0, OP_ACK_RD = 1, OP_ACK_WR = 2,
                   OP_EOI_WR = 3, OP_EOI_RD = 4, OP_OTHER = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        pend_valid = 1'b0, sw_mode = 1'b0, entry_wide = 1'b0;
    logic [3:0]  pend_prio = '0, cur_prio;
    logic [8:0]  pend_vec = '0;
    logic        irq_out, lifo_ovf, lifo_udf;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [3:0]  m_cur = '0;
    logic [3:0]  m_stack [DEPTH];
    int          m_cnt = 0;
    logic [20:0] m_base = '0;
    logic [8:0]  m_vec = '0;
    bit          m_raised = 1'b0, m_ovf = 1'b0, m_udf = 1'b0;

    always #10 clk = ~clk;

    irq_ack_stack #(.DEPTH(DEPTH)) u_irq_ack_stack (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_valid(pend_valid), .pend_prio(pend_prio), .pend_vec(pend_vec),
        .sw_mode(sw_mode), .entry_wide(entry_wide), .irq_out(irq_out),
        .cur_prio(cur_prio), .lifo_ovf(lifo_ovf), .lifo_udf(lifo_udf));

    function automatic logic [31:0] exp_word(logic [20:0] b, logic [8:0] v, bit w);
        if (w) return {b[20:1], v, 3'b000};
        return {b, v, 2'b00};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(bit pv, logic [3:0] pp, logic [8:0] pvec, bit sw,
                        bit wide, int op, logic [31:0] wd);
        bit raw, take, exp_irq;
        logic [8:0] view;
        string tag;
        @(negedge clk);
        pend_valid = pv; pend_prio = pp; pend_vec = pvec;
        sw_mode = sw; entry_wide = wide; bus_wdata = wd;
        bus_sel = (op != OP_IDLE);
        bus_we = (op == OP_ACK_WR) || (op == OP_EOI_WR) || (op == OP_OTHER);
        bus_addr = (op == OP_ACK_RD || op == OP_ACK_WR) ? 8'h10 :
                   (op == OP_EOI_RD || op == OP_EOI_WR) ? 8'h18 : 8'h04;
        #2;
        raw = pv && (pp > m_cur);
        take = (op == OP_ACK_RD) && sw && raw;
        exp_irq = raw && !take;
        view = (!m_raised && raw) ? pvec : m_vec;
        chk(irq_out == exp_irq, take ? "R3 line low on take" : "R2 request line",
            32'(irq_out), 32'(exp_irq));
        if (op == OP_ACK_RD)
            chk(bus_rdata == exp_word(m_base, view, wide),
                wide ? "R8 R9 wide ack word" : "R7 R9 ack word",
                bus_rdata, exp_word(m_base, view, wide));
        if (op == OP_EOI_RD)
            chk(bus_rdata == '0, "R6 eoi read data", bus_rdata, 32'h0);
        tag = "R12 no priority change";
        if (take) begin
            if (m_cnt == DEPTH) begin
                m_ovf = 1'b1; tag = "R10 overflow load";
            end else begin
                m_stack[m_cnt] = m_cur; m_cnt++; tag = "R3 take load";
            end
            m_cur = pp;
        end else if (op == OP_ACK_RD) begin
            tag = "R4 read without take";
        end else if (op == OP_EOI_WR) begin
            if (m_cnt == 0) begin
                m_udf = 1'b1; tag = "R11 empty pop";
            end else begin
                m_cnt--; m_cur = m_stack[m_cnt]; tag = "R5 pop";
            end
        end else if (op == OP_EOI_RD) begin
            tag = "R6 eoi read";
        end else if (op == OP_IDLE) begin
            tag = "R2 idle hold";
        end
        if (op == OP_ACK_WR) m_base = wd[31:11];
        if (!m_raised && raw) m_vec = pvec;
        m_raised = raw && !take;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        chk(cur_prio == m_cur, tag, 32'(cur_prio), 32'(m_cur));
        chk({lifo_ovf, lifo_udf} == {m_ovf, m_udf}, "R10 R11 sticky flags",
            32'({lifo_ovf, lifo_udf}), 32'({m_ovf, m_udf}));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(cur_prio == 4'd0, "R1 reset priority", 32'(cur_prio), 32'h0);
        chk({lifo_ovf, lifo_udf, irq_out} == 3'b000, "R1 reset flags and line",
            32'({lifo_ovf, lifo_udf, irq_out}), 32'h0);
        step(1'b0, 4'd0, 9'd0, 1'b1, 1'b0, OP_ACK_RD, 32'h0);   // R1 zero word
        // R11: pop when empty
        step(1'b0, 4'd0, 9'd0, 1'b0, 1'b0, OP_EOI_WR, 32'hFFFF_FFFF);
        // R12: base write, then unmapped write
        step(1'b0, 4'd0, 9'd0, 1'b0, 1'b0, OP_ACK_WR, 32'hABCD_E9FF);
        step(1'b0, 4'd0, 9'd0, 1'b0, 1'b0, OP_OTHER, 32'h1234_5678);
        // R9: latched vector holds while the pending vector moves
        step(1'b1, 4'd3, 9'h155, 1'b0, 1'b0, OP_IDLE, 32'h0);
        step(1'b1, 4'd3, 9'h0AA, 1'b0, 1'b0, OP_ACK_RD, 32'h0);  // R4, R7
        step(1'b1, 4'd3, 9'h0AA, 1'b0, 1'b1, OP_ACK_RD, 32'h0);  // R8
        // R3 and R10: five nested takes on a four-entry stack
        for (int k = 3; k <= 7; k++)
            step(1'b1, 4'(k), 9'(k * 37), 1'b1, k[0], OP_ACK_RD, 32'h0);
        // R2: equal and lower priorities keep the line low
        step(1'b1, 4'd7, 9'h1, 1'b1, 1'b0, OP_IDLE, 32'h0);
        step(1'b1, 4'd6, 9'h2, 1'b1, 1'b0, OP_EOI_RD, 32'h0);    // R6
        // R5 and R11: drain past empty
        for (int k = 0; k < 6; k++)
            step(1'b0, 4'd0, 9'd0, 1'b1, 1'b0, OP_EOI_WR, $urandom());
        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            int op;
            r = $urandom_range(0, 9);
            op = (r <= 2) ? OP_ACK_RD : (r <= 4) ? OP_EOI_WR : (r == 5) ? OP_EOI_RD :
                 (r == 6) ? OP_ACK_WR : (r == 7) ? OP_OTHER : OP_IDLE;
            step(1'($urandom_range(0, 3) != 0), 4'($urandom()), 9'($urandom()),
                 1'($urandom_range(0, 3) != 0), 1'($urandom()), op, $urandom());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule